// File: doc/BRIEF.md
# Acquisition Synchronization Controller

This block times a data-acquisition unit. It picks a reference-frequency source and a start-event source. It then produces a gated reference pulse train whose first pulse is tied to the chosen start event. Three downstream nodes (ADC, DAC and digital I/O) each receive a clock-enable strobe from their own programmable divider. Because all three dividers are cleared at the start event, the nodes begin in phase.

The reference can come from three places: an internal generator with two selectable rates, an edge of either of two general sync inputs, or a chained reference from a master unit. The start can come from a software command, an edge of either general input, or a chained start from a master. The controller always forwards its internal reference pulse and its running state on chain outputs, so a slave unit can follow it.

Only a software stop ends a run, and it is accepted in any state. Configuration is latched only while the controller is idle.

Top module: `acq_sync_ctrl`

## Requirements
- R1: After reset the status is idle (code 0), and the reference, enable, chain-reference and chain-start outputs are all low.
- R2: The reference select field chooses the source of reference pulses: 0 = internal generator, 1 = general input 1, 2 = general input 2, 3 = rising edge of the chained reference input. Each reference pulse is one clock wide.
- R3: When a general input is the reference source, the reference polarity bit chooses the edge that makes a pulse: 0 = rising, 1 = falling. The other edge makes no pulse.
- R4: The start select field uses the same encoding, with 0 meaning software start and 3 meaning the rising edge of the chained start input. With source 0, a software start moves idle to running (code 2) on the next clock. With any other source, a software start moves idle to armed (code 1), and the selected edge then moves armed to running.
- R5: When a general input is the start source, the start polarity bit chooses the triggering edge (0 = rising, 1 = falling). The other edge leaves the controller armed.
- R6: No reference pulse is output unless the status is running. With the internal source, a reference pulse is output in the first running cycle.
- R7: The internal generator produces one pulse every PER_FAST clocks when the rate bit is 0, and every PER_SLOW clocks when it is 1.
- R8: Each node gives an enable strobe coinciding with every (divisor+1)-th reference pulse, counted from the start event. Node strobes occur only while running.
- R9: The chain reference output equals the reference pulse output in every cycle. The chain start output is high exactly while the status is running.
- R10: A software stop returns the controller to idle on the next clock from armed or running and clears all node counters. External inputs never end a run.
- R11: A configuration write (selects, polarities, rate, divisors) is taken only while idle. A write made while armed or running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ref_sel_i | input | 2 | Reference source select |
| cfg_ref_fall_i | input | 1 | Reference edge polarity for general inputs |
| cfg_start_sel_i | input | 2 | Start source select |
| cfg_start_fall_i | input | 1 | Start edge polarity for general inputs |
| cfg_int_slow_i | input | 1 | Internal generator rate, 1 = slow |
| cfg_div_i | input | NODES*DW | Node divisors, node n at bits [n*DW +: DW] |
| sw_start_i | input | 1 | Software start/arm command pulse |
| sw_stop_i | input | 1 | Software stop command pulse |
| gp1_i | input | 1 | General sync input 1 (asynchronous) |
| gp2_i | input | 1 | General sync input 2 (asynchronous) |
| chain_ref_i | input | 1 | Reference from master unit (asynchronous) |
| chain_start_i | input | 1 | Start from master unit (asynchronous) |
| ref_pulse_o | output | 1 | Gated internal reference pulse |
| node_en_o | output | NODES | Per-node enable strobes (0 ADC, 1 DAC, 2 DIO) |
| chain_ref_o | output | 1 | Forwarded reference pulse for a slave |
| chain_start_o | output | 1 | Forwarded running level for a slave |
| state_o | output | 2 | Status: 0 idle, 1 armed, 2 running |

## Verification
Some properties are checked by assertions on every cycle:
- reference and node strobes stay silent outside running;
- a stop lands in idle on the next clock;
- latched configuration is frozen outside idle;
- the armed state is reachable only with an external start source;
- the internal source emits a pulse in the first running cycle.

Other behaviour can only be shown by the bench scenarios. These include the exact generator periods, the divide-by-(divisor+1) counts, and the edge polarity selection through the synchronizers. They also include the fact that a stop clears partial divider counts, and that writes made while running have no effect.

// File: rtl/acq_sync_pkg.sv
package acq_sync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } sync_state_e;

  typedef enum logic [1:0] {
    SRC_INT   = 2'd0,
    SRC_GP1   = 2'd1,
    SRC_GP2   = 2'd2,
    SRC_CHAIN = 2'd3
  } src_sel_e;

  typedef struct packed {
    src_sel_e ref_sel;
    logic     ref_fall;
    src_sel_e start_sel;
    logic     start_fall;
    logic     int_slow;
  } sync_cfg_t;

  // bit positions of the asynchronous inputs in the synchronizer vector
  localparam int unsigned IN_GP1   = 0;
  localparam int unsigned IN_GP2   = 1;
  localparam int unsigned IN_CREF  = 2;
  localparam int unsigned IN_CST   = 3;
  localparam int unsigned IN_COUNT = 4;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  // STAGES synchronizer flops plus one history stage
  logic [STAGES:0][W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/int_ref_gen.sv
module int_ref_gen #(
  parameter int unsigned PER_FAST = 60,
  parameter int unsigned PER_SLOW = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PMAX = (PER_SLOW > PER_FAST) ? PER_SLOW : PER_FAST;
  localparam int unsigned CW   = $clog2(PMAX);
  localparam logic [CW-1:0] LIM_F = CW'(PER_FAST - 1);
  localparam logic [CW-1:0] LIM_S = CW'(PER_SLOW - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = slow_i ? LIM_S : LIM_F;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (restart_i)    cnt_q <= '0;
    else if (cnt_q >= lim) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == '0);

  p_restart_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> tick_o);
endmodule

// File: rtl/node_div.sv
module node_div #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ref_i,
  input  logic [DW-1:0] div_i,
  output logic          en_o
);
  logic [DW-1:0] cnt_q;
  logic          hit;

  assign hit  = (cnt_q >= div_i);
  assign en_o = ref_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (ref_i)  cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  p_clr_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/acq_sync_ctrl.sv
module acq_sync_ctrl
  import acq_sync_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned NODES    = 3,
  parameter int unsigned STAGES   = 2,
  parameter int unsigned PER_FAST = 60,
  parameter int unsigned PER_SLOW = 80
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_ref_sel_i,
  input  logic                cfg_ref_fall_i,
  input  logic [1:0]          cfg_start_sel_i,
  input  logic                cfg_start_fall_i,
  input  logic                cfg_int_slow_i,
  input  logic [NODES*DW-1:0] cfg_div_i,
  input  logic                sw_start_i,
  input  logic                sw_stop_i,
  input  logic                gp1_i,
  input  logic                gp2_i,
  input  logic                chain_ref_i,
  input  logic                chain_start_i,
  output logic                ref_pulse_o,
  output logic [NODES-1:0]    node_en_o,
  output logic                chain_ref_o,
  output logic                chain_start_o,
  output logic [1:0]          state_o
);
  sync_state_e               state_q, state_d;
  sync_cfg_t                 cfg_q;
  logic [NODES-1:0][DW-1:0]  div_q;
  logic [IN_COUNT-1:0]       async_v, rise_v, fall_v;
  logic [1:0]                ref_idx, st_idx;
  logic                      ref_pol, st_pol, ref_edge, st_edge;
  logic                      int_tick, ref_tick, start_fire, running;

  // configuration latch, open only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      div_q <= '0;
    end else if (cfg_we_i && state_q == ST_IDLE) begin
      cfg_q <= '{ref_sel:    src_sel_e'(cfg_ref_sel_i),
                 ref_fall:   cfg_ref_fall_i,
                 start_sel:  src_sel_e'(cfg_start_sel_i),
                 start_fall: cfg_start_fall_i,
                 int_slow:   cfg_int_slow_i};
      div_q <= cfg_div_i;
    end
  end

  assign async_v = {chain_start_i, chain_ref_i, gp2_i, gp1_i};

  sync_edge #(.W(IN_COUNT), .STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (async_v),
    .rise_o (rise_v),
    .fall_o (fall_v)
  );

  // chained inputs always use the rising edge
  always_comb begin
    unique case (cfg_q.ref_sel)
      SRC_GP1: ref_idx = 2'(IN_GP1);
      SRC_GP2: ref_idx = 2'(IN_GP2);
      default: ref_idx = 2'(IN_CREF);
    endcase
    unique case (cfg_q.start_sel)
      SRC_GP1: st_idx = 2'(IN_GP1);
      SRC_GP2: st_idx = 2'(IN_GP2);
      default: st_idx = 2'(IN_CST);
    endcase
    ref_pol  = cfg_q.ref_fall & (cfg_q.ref_sel != SRC_CHAIN);
    st_pol   = cfg_q.start_fall & (cfg_q.start_sel != SRC_CHAIN);
    ref_edge = ref_pol ? fall_v[ref_idx] : rise_v[ref_idx];
    st_edge  = (cfg_q.start_sel != SRC_INT) &&
               (st_pol ? fall_v[st_idx] : rise_v[st_idx]);
    ref_tick = (cfg_q.ref_sel == SRC_INT) ? int_tick : ref_edge;
  end

  always_comb begin
    state_d    = state_q;
    start_fire = 1'b0;
    if (sw_stop_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:
          if (sw_start_i) begin
            if (cfg_q.start_sel == SRC_INT) begin
              state_d    = ST_RUN;
              start_fire = 1'b1;
            end else begin
              state_d = ST_ARMED;
            end
          end
        ST_ARMED:
          if (st_edge) begin
            state_d    = ST_RUN;
            start_fire = 1'b1;
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  int_ref_gen #(.PER_FAST(PER_FAST), .PER_SLOW(PER_SLOW)) u_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slow_i    (cfg_q.int_slow),
    .restart_i (start_fire),
    .tick_o    (int_tick)
  );

  assign running     = (state_q == ST_RUN);
  assign ref_pulse_o = running & ref_tick;

  for (genvar g = 0; g < NODES; g++) begin : g_node
    node_div #(.DW(DW)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (start_fire | sw_stop_i),
      .ref_i  (ref_pulse_o),
      .div_i  (div_q[g]),
      .en_o   (node_en_o[g])
    );
  end

  assign chain_ref_o   = ref_pulse_o;
  assign chain_start_o = running;
  assign state_o       = state_q;

  p_gated_ref_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN) |-> !ref_pulse_o);
  p_first_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(state_q == ST_RUN) && cfg_q.ref_sel == SRC_INT) |-> ref_pulse_o);
  p_en_in_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (node_en_o != '0) |-> (state_q == ST_RUN));
  p_stop_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_stop_i |=> (state_q == ST_IDLE));
  p_cfg_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> ($stable(cfg_q) && $stable(div_q)));
  p_armed_ext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED) |-> (cfg_q.start_sel != SRC_INT));
endmodule

// File: tb/sim_acq_sync_ctrl.sv
module sim_acq_sync_ctrl;
  localparam int DW = 16, NN = 3, PF = 6, PS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           cfg_we = 0, ref_fall = 0, st_fall = 0, slow = 0;
  logic [1:0]     ref_sel = 0, st_sel = 0;
  logic [NN*DW-1:0] div = '0;
  logic           sw_start = 0, sw_stop = 0, gp1 = 0, gp2 = 0, c_ref_in = 0, c_st_in = 0;
  logic           ref_pulse, chain_ref, chain_start;
  logic [NN-1:0]  node_en;
  logic [1:0]     state;

  acq_sync_ctrl #(.DW(DW), .NODES(NN), .PER_FAST(PF), .PER_SLOW(PS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ref_sel_i(ref_sel),
    .cfg_ref_fall_i(ref_fall), .cfg_start_sel_i(st_sel), .cfg_start_fall_i(st_fall),
    .cfg_int_slow_i(slow), .cfg_div_i(div), .sw_start_i(sw_start), .sw_stop_i(sw_stop),
    .gp1_i(gp1), .gp2_i(gp2), .chain_ref_i(c_ref_in), .chain_start_i(c_st_in),
    .ref_pulse_o(ref_pulse), .node_en_o(node_en), .chain_ref_o(chain_ref),
    .chain_start_o(chain_start), .state_o(state)
  );

  int n_tests = 0, n_fail = 0;
  int c_ref, c_mis, c_notrun, first_en2;
  int c_en [NN];

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // samples n consecutive negedges, the current one first
  task automatic window(int n);
    c_ref = 0; c_mis = 0; c_notrun = 0; first_en2 = -1;
    for (int k = 0; k < NN; k++) c_en[k] = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      c_ref += int'(ref_pulse);
      for (int k = 0; k < NN; k++) c_en[k] += int'(node_en[k]);
      if (chain_ref != ref_pulse || chain_start != (state == 2'd2)) c_mis++;
      if (state != 2'd2) c_notrun++;
      if (node_en[2] && first_en2 < 0) first_en2 = i;
    end
  endtask

  task automatic cfg_write(logic [1:0] rs, logic rf, logic [1:0] ss, logic sf, logic sl,
                           int d0, int d1, int d2);
    ref_sel = rs; ref_fall = rf; st_sel = ss; st_fall = sf; slow = sl;
    div = {DW'(d2), DW'(d1), DW'(d0)};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic go();
    sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic halt();
    sw_stop = 1'b1; @(negedge clk); sw_stop = 1'b0;
  endtask

  task automatic wait_run(output bit ok);
    ok = 0;
    for (int i = 0; i < 10 && !ok; i++) begin
      @(negedge clk);
      ok = (state == 2'd2);
    end
  endtask

  task automatic t_reset();
    chk(state == 2'd0, "R1 state", state, 0);
    chk(!ref_pulse && node_en == '0, "R1 ref/en", {ref_pulse, node_en}, 0);
    chk(!chain_ref && !chain_start, "R1 chain", {chain_ref, chain_start}, 0);
  endtask

  task automatic t_int_fast();
    cfg_write(2'd0, 0, 2'd0, 0, 0, 0, 1, 2);
    go();
    chk(state == 2'd2, "R4 sw start runs", state, 2);
    chk(ref_pulse == 1'b1, "R6 first pulse", ref_pulse, 1);
    chk(chain_start == 1'b1, "R9 chain start", chain_start, 1);
    window(60);
    chk(c_ref == 10, "R7 fast count", c_ref, 10);
    chk(c_en[0] == 10, "R8 node0 div1", c_en[0], 10);
    chk(c_en[1] == 5, "R8 node1 div2", c_en[1], 5);
    chk(c_en[2] == 3, "R8 node2 div3", c_en[2], 3);
    chk(c_mis == 0, "R9 chain mirror", c_mis, 0);
    halt();
    chk(state == 2'd0 && !chain_start, "R10 stop run", state, 0);
  endtask

  task automatic t_slow_frozen();
    cfg_write(2'd0, 0, 2'd0, 0, 1, 0, 0, 0);
    go();
    window(64);
    chk(c_ref == 8, "R7 slow count", c_ref, 8);
    cfg_write(2'd1, 1, 2'd1, 0, 0, 5, 5, 5);
    chk(state == 2'd2, "R11 write no effect on state", state, 2);
    window(64);
    chk(c_ref == 8, "R11 rate kept", c_ref, 8);
    chk(c_en[0] == 8, "R11 divisor kept", c_en[0], 8);
    halt();
  endtask

  task automatic t_clear();
    cfg_write(2'd0, 0, 2'd0, 0, 0, 0, 0, 2);
    go();
    window(8);
    chk(c_ref == 2 && c_en[2] == 0, "R8 partial count", c_en[2], 0);
    halt();
    go();
    window(13);
    chk(c_en[2] == 1, "R10 counters cleared", c_en[2], 1);
    chk(first_en2 == 12, "R10 enable on third pulse", first_en2, 12);
    halt();
  endtask

  task automatic t_ext_start_rise();
    bit ok;
    gp1 = 0; gp2 = 1;
    cfg_write(2'd2, 1, 2'd1, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    go();
    chk(state == 2'd1, "R4 armed", state, 1);
    gp2 = 0;
    window(8);
    chk(c_ref == 0 && c_notrun == 8, "R6 no pulse while armed", c_ref, 0);
    gp1 = 1;
    wait_run(ok);
    chk(ok, "R4 gp1 rising starts", state, 2);
    gp2 = 1;
    window(8);
    chk(c_ref == 0, "R3 rising ignored", c_ref, 0);
    gp2 = 0;
    window(8);
    chk(c_ref == 1, "R2 gp2 falling pulse", c_ref, 1);
    gp1 = 0; c_st_in = 1;
    window(8);
    chk(c_notrun == 0, "R10 inputs do not stop", c_notrun, 0);
    c_st_in = 0;
    halt();
  endtask

  task automatic t_chain_ref_fall_start();
    bit ok;
    gp2 = 0;
    cfg_write(2'd3, 1, 2'd2, 1, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    go();
    c_ref_in = 1; window(4);
    chk(c_ref == 0, "R6 chain ref held while armed", c_ref, 0);
    c_ref_in = 0; repeat (4) @(negedge clk);
    gp2 = 1;
    window(6);
    chk(state == 2'd1, "R5 rising leaves armed", state, 1);
    gp2 = 0;
    wait_run(ok);
    chk(ok, "R5 falling starts", state, 2);
    c_ref_in = 1;
    window(6);
    chk(c_ref == 1, "R2 chain ref pulse", c_ref, 1);
    chk(c_mis == 0, "R9 chain mirror ext", c_mis, 0);
    c_ref_in = 0; repeat (4) @(negedge clk);
    halt();
  endtask

  task automatic t_chain_start();
    bit ok;
    cfg_write(2'd0, 0, 2'd3, 0, 0, 0, 0, 0);
    go();
    chk(state == 2'd1, "R4 armed chain", state, 1);
    c_st_in = 1;
    wait_run(ok);
    chk(ok && ref_pulse, "R6 pulse at chain start", {ok, ref_pulse}, 3);
    c_st_in = 0;
    halt();
  endtask

  task automatic t_stop_armed();
    gp1 = 0;
    cfg_write(2'd0, 0, 2'd1, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    go();
    halt();
    chk(state == 2'd0, "R10 stop armed", state, 0);
    gp1 = 1;
    window(8);
    chk(state == 2'd0 && c_ref == 0, "R10 idle after stop", state, 0);
    gp1 = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_int_fast();
    t_slow_frozen();
    t_clear();
    t_ext_start_rise();
    t_chain_ref_fall_start();
    t_chain_start();
    t_stop_armed();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule